// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block takes frames that have already passed address filtering and stores them into a circular receive area of local packet memory. The memory is divided into 256-byte pages. Software sets the first page of the ring, the page just past its end, a boundary page, which marks how far software has consumed the ring, and the current page, where the next frame will land. All of these are set through a small byte-wide register port.

A frame arrives as a byte stream with first-beat and last-beat markers. When the frame starts, the block checks the halt bit and the free space in the ring, and either accepts the whole frame or discards the whole frame. An accepted frame is written as payload first. The payload starts four bytes into the current page, wraps from the end of the ring back to its start, is truncated at 1514 bytes, and is padded with zeros up to 60 bytes. The four-byte header at the current page is written after the payload. The block then moves the current page to the page after the frame and raises a receive interrupt flag.

A frame that arrives while the previous one is still being finished is held off by the ready signal.

Top module: `rxring_writer`

## Requirements
- R1: After reset: the halt bit (register 0, bit 0) reads 1. Registers 1 to 4 (ring first page, ring limit page, boundary page, current page), the interrupt register 5 and the status register 6 read 0. `rxIrq` is 0 and no memory write occurs.
- R2: While the halt bit is set, every frame is consumed and discarded. There is no memory write, and neither the current page nor the interrupt flag changes.
- R3: At the first beat, free pages are computed as follows:
  - if current ≤ boundary, free pages = boundary − current;
  - otherwise, free pages = (limit − first) − (current − boundary).
  
  The frame is discarded whole when free pages × 256 < 1518, and accepted otherwise.
- R4: A frame with fewer than 60 stored bytes is extended with zero bytes until 60 bytes are stored.
- R5: Only the first 1514 bytes of a frame are stored. Later bytes are consumed and ignored.
- R6: Payload byte k goes to the address that follows the previous one, and the first payload byte goes to current×256+4. An address that reaches limit×256 continues at first×256.
- R7: After the payload, four header bytes are written to current×256+0..3, in this order: status, next page, length low byte, length high byte. The length is the stored byte count plus 4.
- R8: Next page = current + floor((length+4+255)/256). If the result is ≥ limit, it is reduced by (limit − first). The current page (register 4) takes this value after the header is written.
- R9: The status byte is 0x01, with bit 5 (0x20) also set when bit 0 of the frame's first byte is 1. Register 6 holds the status of the last stored frame.
- R10: Storing a frame sets the interrupt flag, which is seen as register 5 bit 0 and as `rxIrq`. Writing 1 to register 5 bit 0 clears the flag.
- R11: `inReady` is low from the cycle after a frame's last beat until the frame has been stored. At most one memory write occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select (0 control, 1 first, 2 limit, 3 boundary, 4 current, 5 interrupt, 6 status) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` (combinational) |
| inValid | input | 1 | Frame byte valid |
| inFirst | input | 1 | Marks the first byte of a frame |
| inLast | input | 1 | Marks the last byte of a frame |
| inData | input | 8 | Frame byte |
| inReady | output | 1 | Byte is accepted on a clock edge when high |
| memWe | output | 1 | Packet memory write enable |
| memAddr | output | 16 | Packet memory byte address |
| memData | output | 8 | Packet memory write data |
| rxIrq | output | 1 | Receive interrupt flag |

## Verification
Every memory write appears on the registered memory port in the cycle after its cause:
- a payload byte is written one cycle after the edge that accepts it;
- each pad byte and each header byte is written one cycle after its own control cycle.

A driver computes the full expected write list of each frame into a queue. A monitor samples the memory port on the falling clock edge and pops one entry per observed write. Any write while the queue is empty is reported as a failure, which also covers frames that are halted or refused.

The current page, the status and the interrupt flag settle one cycle after the last header write. They are read only after a fixed settle delay, longer than the worst-case padding plus header time. The ready drop is sampled at the falling edge that directly follows the edge accepting the last beat.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  localparam int PAGE_W = 8;
  localparam int OFF_W  = 8;
  localparam int ADDR_W = PAGE_W + OFF_W;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_FIRST = 3'd1;
  localparam logic [2:0] REG_LIMIT = 3'd2;
  localparam logic [2:0] REG_BOUND = 3'd3;
  localparam logic [2:0] REG_CUR   = 3'd4;
  localparam logic [2:0] REG_INT   = 3'd5;
  localparam logic [2:0] REG_STAT  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_PAD,
    ST_HDR,
    ST_DONE
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic storeByte;
    logic padByte;
    logic hdrByte;
    logic commit;
  } rxStrobe_t;

endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inFirst,
  input  logic      inLast,
  input  logic      haltOn,
  input  logic      spaceOk,
  input  logic      padDone,
  input  logic      hdrLast,
  output logic      inReady,
  output logic      idle,
  output rxStrobe_t stb
);

  rxState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    inReady   = (state == ST_IDLE) || (state == ST_RECV) || (state == ST_DROP);
    idle      = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (inValid && inFirst) begin
          if (haltOn || !spaceOk) begin
            nextState = inLast ? ST_IDLE : ST_DROP;
          end else begin
            stb.startFrame = 1'b1;
            stb.storeByte  = 1'b1;
            nextState      = inLast ? ST_PAD : ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (inValid) begin
          stb.storeByte = 1'b1;
          if (inLast) nextState = ST_PAD;
        end
      end
      ST_DROP: begin
        if (inValid && inLast) nextState = ST_IDLE;
      end
      ST_PAD: begin
        if (padDone) nextState = ST_HDR;
        else         stb.padByte = 1'b1;
      end
      ST_HDR: begin
        stb.hdrByte = 1'b1;
        if (hdrLast) nextState = ST_DONE;
      end
      ST_DONE: begin
        stb.commit = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int MinLen = 60,
  parameter int MaxLen = 1514,
  parameter int HdrLen = 4,
  parameter int CrcLen = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         stb,
  input  logic [7:0]        inData,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              haltOn,
  output logic              spaceOk,
  output logic              padDone,
  output logic              hdrLast,
  output logic              rxIrq,
  output logic [PAGE_W-1:0] curPg
);

  localparam int CntW    = $clog2(MaxLen + 1);
  localparam int HdrIdxW = $clog2(HdrLen);
  localparam logic [ADDR_W-1:0] SpaceNeed = ADDR_W'(MaxLen + CrcLen);

  logic [PAGE_W-1:0]  firstPg, limitPg, bndPg;
  logic               haltBit, intFlag, mcastSeen;
  logic [7:0]         lastStat;
  logic [ADDR_W-1:0]  wrPtr;
  logic [CntW-1:0]    byteCnt;
  logic [HdrIdxW-1:0] hdrIdx;

  logic [PAGE_W-1:0] ringPages, freePages, nextPg;
  logic [15:0]       lenVal, pagesUsed;
  logic [PAGE_W:0]   pageSum;
  logic [ADDR_W-1:0] storeAddr;
  logic              storeEn;
  logic [7:0]        statusByte, hdrData;

  function automatic logic [ADDR_W-1:0] stepAddr(
    input logic [ADDR_W-1:0] a,
    input logic [PAGE_W-1:0] fp,
    input logic [PAGE_W-1:0] lp
  );
    logic [ADDR_W-1:0] n;
    n = a + 1'b1;
    if (n == {lp, {OFF_W{1'b0}}}) n = {fp, {OFF_W{1'b0}}};
    return n;
  endfunction

  // Free space, measured from the current page up to the boundary page.
  always_comb begin
    ringPages = limitPg - firstPg;
    if (curPg <= bndPg) freePages = bndPg - curPg;
    else                freePages = ringPages - (curPg - bndPg);
    spaceOk = {freePages, {OFF_W{1'b0}}} >= SpaceNeed;
  end

  // Length, next page and the header contents.
  always_comb begin
    lenVal     = 16'(byteCnt) + 16'(HdrLen);
    pagesUsed  = (lenVal + 16'(CrcLen) + 16'd255) >> OFF_W;
    pageSum    = {1'b0, curPg} + pagesUsed[PAGE_W:0];
    if (pageSum >= {1'b0, limitPg}) nextPg = PAGE_W'(pageSum - {1'b0, ringPages});
    else                            nextPg = pageSum[PAGE_W-1:0];
    statusByte = 8'h01 | (mcastSeen ? 8'h20 : 8'h00);
    case (hdrIdx)
      HdrIdxW'(0): hdrData = statusByte;
      HdrIdxW'(1): hdrData = 8'(nextPg);
      HdrIdxW'(2): hdrData = lenVal[7:0];
      default:     hdrData = lenVal[15:8];
    endcase
  end

  assign storeAddr = stb.startFrame ? {curPg, OFF_W'(HdrLen)} : wrPtr;
  assign storeEn   = stb.storeByte && (stb.startFrame || (byteCnt < CntW'(MaxLen)));
  assign padDone   = byteCnt >= CntW'(MinLen);
  assign hdrLast   = hdrIdx == HdrIdxW'(HdrLen - 1);
  assign haltOn    = haltBit;
  assign rxIrq     = intFlag;

  always_comb begin
    case (regAddr)
      REG_CTRL:  regRdata = {7'd0, haltBit};
      REG_FIRST: regRdata = 8'(firstPg);
      REG_LIMIT: regRdata = 8'(limitPg);
      REG_BOUND: regRdata = 8'(bndPg);
      REG_CUR:   regRdata = 8'(curPg);
      REG_INT:   regRdata = {7'd0, intFlag};
      REG_STAT:  regRdata = lastStat;
      default:   regRdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltBit   <= 1'b1;
      firstPg   <= '0;
      limitPg   <= '0;
      bndPg     <= '0;
      curPg     <= '0;
      intFlag   <= 1'b0;
      lastStat  <= '0;
      mcastSeen <= 1'b0;
      wrPtr     <= '0;
      byteCnt   <= '0;
      hdrIdx    <= '0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
    end else begin
      if (regWe) begin
        case (regAddr)
          REG_CTRL:  haltBit <= regWdata[0];
          REG_FIRST: firstPg <= PAGE_W'(regWdata);
          REG_LIMIT: limitPg <= PAGE_W'(regWdata);
          REG_BOUND: bndPg   <= PAGE_W'(regWdata);
          REG_CUR:   curPg   <= PAGE_W'(regWdata);
          REG_INT:   if (regWdata[0]) intFlag <= 1'b0;
          default: ;
        endcase
      end
      memWe <= 1'b0;
      if (stb.startFrame) begin
        mcastSeen <= inData[0];
        hdrIdx    <= '0;
      end
      if (storeEn) begin
        wrPtr   <= stepAddr(storeAddr, firstPg, limitPg);
        byteCnt <= stb.startFrame ? CntW'(1) : byteCnt + 1'b1;
        memWe   <= 1'b1;
        memAddr <= storeAddr;
        memData <= inData;
      end
      if (stb.padByte) begin
        wrPtr   <= stepAddr(wrPtr, firstPg, limitPg);
        byteCnt <= byteCnt + 1'b1;
        memWe   <= 1'b1;
        memAddr <= wrPtr;
        memData <= 8'h00;
      end
      if (stb.hdrByte) begin
        hdrIdx  <= hdrIdx + 1'b1;
        memWe   <= 1'b1;
        memAddr <= {curPg, (OFF_W - HdrIdxW)'(0), hdrIdx};
        memData <= hdrData;
      end
      if (stb.commit) begin
        curPg    <= nextPg;
        intFlag  <= 1'b1;
        lastStat <= statusByte;
      end
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int MinLen = 60,
  parameter int MaxLen = 1514,
  parameter int HdrLen = 4,
  parameter int CrcLen = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        inLast,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        memWe,
  output logic [15:0] memAddr,
  output logic [7:0]  memData,
  output logic        rxIrq
);

  rxStrobe_t         stb;
  logic              haltOn, spaceOk, padDone, hdrLast, idle;
  logic [PAGE_W-1:0] curPg;

  rxring_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .haltOn(haltOn), .spaceOk(spaceOk), .padDone(padDone), .hdrLast(hdrLast),
    .inReady(inReady), .idle(idle), .stb(stb)
  );

  rxring_dp #(.MinLen(MinLen), .MaxLen(MaxLen), .HdrLen(HdrLen), .CrcLen(CrcLen)) dpInst (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .haltOn(haltOn), .spaceOk(spaceOk), .padDone(padDone), .hdrLast(hdrLast),
    .rxIrq(rxIrq), .curPg(curPg)
  );

endmodule

// File: rtl/rxring_checker.sv
module rxring_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inFirst,
  input logic       inReady,
  input logic       memWe,
  input logic [7:0] memData,
  input logic       rxIrq,
  input logic       regWe,
  input logic [2:0] regAddr,
  input logic       idle,
  input logic       haltOn,
  input logic       storeStb,
  input logic       padStb,
  input logic       hdrStb,
  input logic       commitStb,
  input logic [7:0] curPage
);

  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (idle && inValid && inFirst && haltOn) |=> !memWe); // R2

  AST_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    padStb |=> (memWe && memData == 8'h00)); // R4

  AST_CUR_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curPage) |-> ($past(commitStb) || $past(regWe && regAddr == 3'd4))); // R8

  AST_IRQ_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> rxIrq); // R10

  AST_NOT_READY_IN_HDR: assert property (@(posedge clk) disable iff (!rstN)
    (hdrStb || padStb || commitStb) |-> !inReady); // R11

  AST_ONE_WRITE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeStb, padStb, hdrStb, commitStb})); // R11

endmodule

bind rxring_writer rxring_checker chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst), .inReady(inReady),
  .memWe(memWe), .memData(memData), .rxIrq(rxIrq), .regWe(regWe), .regAddr(regAddr),
  .idle(idle), .haltOn(haltOn), .storeStb(stb.storeByte), .padStb(stb.padByte),
  .hdrStb(stb.hdrByte), .commitStb(stb.commit), .curPage(8'(curPg))
);

// File: tb/rxring_writer_test.sv
`timescale 1ns/1ps
module rxring_writer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWdata = 8'd0;
  logic [7:0]  regRdata;
  logic        inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [7:0]  inData = 8'd0;
  logic        inReady, memWe, rxIrq;
  logic [15:0] memAddr;
  logic [7:0]  memData;

  int checks = 0;
  int fails = 0;
  logic [23:0] expQ[$];
  logic [7:0]  frameBuf[$];

  always #10 clk = ~clk;

  rxring_writer uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .inData(inData), .inReady(inReady), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .rxIrq(rxIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every memory write must match the next expected entry (R6 R7).
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 R3 unexpected write", int'({memAddr, memData}), 0);
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        check({memAddr, memData} == e, "R6 R7 write", int'({memAddr, memData}), int'(e));
      end
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic fillFrame(input int n, input logic [7:0] b0, input int seed);
    frameBuf.delete();
    frameBuf.push_back(b0);
    for (int i = 1; i < n; i++) frameBuf.push_back(8'(((i * 13 + seed) % 255) + 1));
  endtask

  function automatic int ringStep(input int a, input int fp, input int lp);
    int n;
    n = a + 1;
    if (n == lp * 256) n = fp * 256;
    return n;
  endfunction

  task automatic expectFrame(input int cp, input int fp, input int lp, output int np);
    int a, kept, stored, len, pg;
    logic [7:0] st;
    a = cp * 256 + 4;
    kept = (frameBuf.size() > 1514) ? 1514 : frameBuf.size();
    for (int i = 0; i < kept; i++) begin
      expQ.push_back({16'(a), frameBuf[i]});
      a = ringStep(a, fp, lp);
    end
    stored = kept;
    while (stored < 60) begin
      expQ.push_back({16'(a), 8'h00});
      a = ringStep(a, fp, lp);
      stored++;
    end
    len = stored + 4;
    pg = (len + 4 + 255) / 256;
    np = cp + pg;
    if (np >= lp) np = np - (lp - fp);
    st = frameBuf[0][0] ? 8'h21 : 8'h01;
    expQ.push_back({16'(cp * 256 + 0), st});
    expQ.push_back({16'(cp * 256 + 1), 8'(np)});
    expQ.push_back({16'(cp * 256 + 2), 8'(len)});
    expQ.push_back({16'(cp * 256 + 3), 8'(len >> 8)});
  endtask

  task automatic sendFrame();
    for (int i = 0; i < frameBuf.size(); i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inFirst = (i == 0);
      inLast  = (i == frameBuf.size() - 1);
      inData  = frameBuf[i];
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
    check(expQ.size() == 0, "R7 all writes done", expQ.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int np;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(3'd0, v); check(v == 8'h01, "R1 halt", v, 1);
    for (int r = 1; r <= 6; r++) begin
      readReg(3'(r), v); check(v == 8'h00, "R1 reg zero", v, 0);
    end
    check(rxIrq == 1'b0 && memWe == 1'b0, "R1 irq/mem", {rxIrq, memWe}, 0);

    writeReg(3'd1, 8'h40);
    writeReg(3'd2, 8'h60);
    writeReg(3'd3, 8'h5F);
    writeReg(3'd4, 8'h40);

    // R2 halted: frame dropped
    fillFrame(20, 8'h02, 1);
    sendFrame();
    repeat (80) @(negedge clk);
    readReg(3'd4, v); check(v == 8'h40, "R2 current page", v, 8'h40);
    check(rxIrq == 1'b0, "R2 irq", rxIrq, 0);
    writeReg(3'd0, 8'h00);

    // R4 short unicast frame padded
    fillFrame(10, 8'h02, 3);
    expectFrame(8'h40, 8'h40, 8'h60, np);
    sendFrame();
    check(inReady == 1'b0, "R11 ready low after last", inReady, 0);
    settle();
    readReg(3'd4, v); check(v == 8'h41, "R8 current page", v, 8'h41);
    readReg(3'd6, v); check(v == 8'h01, "R9 unicast status", v, 8'h01);
    check(rxIrq == 1'b1, "R10 irq set", rxIrq, 1);
    readReg(3'd5, v); check(v == 8'h01, "R10 int reg", v, 1);
    writeReg(3'd5, 8'h01);
    check(rxIrq == 1'b0, "R10 irq cleared", rxIrq, 0);

    // R9 multicast destination
    fillFrame(100, 8'h01, 5);
    expectFrame(8'h41, 8'h40, 8'h60, np);
    sendFrame();
    settle();
    readReg(3'd6, v); check(v == 8'h21, "R9 multicast status", v, 8'h21);
    readReg(3'd4, v); check(v == 8'(np), "R8 current page", v, np);

    // R11 back-to-back frames held off by ready
    fillFrame(60, 8'h04, 7);
    expectFrame(8'h42, 8'h40, 8'h60, np);
    sendFrame();
    fillFrame(300, 8'h06, 9);
    expectFrame(np, 8'h40, 8'h60, np);
    sendFrame();
    settle();
    readReg(3'd4, v); check(v == 8'h45, "R11 R8 back-to-back page", v, 8'h45);

    // R6 R8 wrap at the limit page
    writeReg(3'd4, 8'h5E);
    writeReg(3'd3, 8'h5D);
    fillFrame(700, 8'h08, 11);
    expectFrame(8'h5E, 8'h40, 8'h60, np);
    sendFrame();
    settle();
    readReg(3'd4, v); check(v == 8'h41, "R8 wrapped page", v, 8'h41);

    // R3 refused: only 4 free pages
    writeReg(3'd5, 8'h01);
    writeReg(3'd3, 8'h45);
    fillFrame(64, 8'h02, 13);
    sendFrame();
    repeat (80) @(negedge clk);
    readReg(3'd4, v); check(v == 8'h41, "R3 refused page", v, 8'h41);
    check(rxIrq == 1'b0, "R3 refused irq", rxIrq, 0);

    // R3 exactly 6 free pages: accepted
    writeReg(3'd3, 8'h47);
    fillFrame(60, 8'h02, 15);
    expectFrame(8'h41, 8'h40, 8'h60, np);
    sendFrame();
    settle();
    readReg(3'd4, v); check(v == 8'h42, "R3 edge accepted page", v, 8'h42);

    // R5 truncation to 1514
    writeReg(3'd3, 8'h41);
    fillFrame(1600, 8'h0A, 17);
    expectFrame(8'h42, 8'h40, 8'h60, np);
    sendFrame();
    settle();
    readReg(3'd4, v); check(v == 8'h48, "R5 truncated next page", v, 8'h48);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule